// File: doc/BRIEF.md
# Burst Word Address Sequencer

This block steps through the word addresses of one page or burst access to an external memory device. When it is idle and a start request arrives, it captures the start byte address, the direction and the burst settings of the target chip select. These settings are the length code, wrap enable, separate read and write burst enables, device width and the inter-word gap. From the next cycle it presents one beat per word on its outputs. The beats are separated by the programmed number of idle cycles, and the final one is marked. A direction whose burst enable is clear is served as a single word. Strobe and bus-clock generation sit in a neighbouring block that consumes these beats.

The controller has three states. `ST_IDLE` waits for a start. `ST_BEAT` presents one word. `ST_GAP` counts out the inter-word delay. The transitions are:
- idle-to-beat: a start is seen while idle.
- beat-to-beat: more words remain and the gap is zero.
- beat-to-gap: more words remain and the gap is non-zero.
- gap-to-beat: the gap timer expires.
- beat-to-idle: the final word has been presented.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset `ready_o` is 1, and `beat_o` and `last_o` are 0.
- R2: A start sampled while `ready_o` is 1 produces the first beat in the next cycle, at the start address. `wr_o` carries the captured direction (1 = write).
- R3: Length code `len_sel_i` gives the word count: 0 = 1 word, 1 = 4, 2 = 8, 3 = 16. `last_o` is high only together with the final beat.
- R4: The burst enable is chosen by direction: `wr_burst_en_i` for writes, `rd_burst_en_i` for reads. When the selected enable is 0 the access is a single word, whatever the length code.
- R5: `wide_i` = 0 selects 1-byte words (step 1). `wide_i` = 1 selects 2-byte words (step 2), and bit 0 of every address is then forced to 0.
- R6: With wrap off, the address steps linearly from the start address, modulo 2^ADDR_W.
- R7: With wrap on, the address stays inside the window of (word count × bytes) that is aligned to that size and contains the start address. It wraps to the window base instead of leaving the window.
- R8: `gap_i` idle cycles (`beat_o` = 0, `addr_o` held) separate successive beats. A gap of 0 gives back-to-back beats.
- R9: The cycle after the final beat has `ready_o` = 1, and a start sampled in that cycle is accepted.
- R10: A start while busy is ignored. No extra beats appear and the running burst is unchanged.
- R11: All settings are captured at the start. Input changes during a burst have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, taken when ready |
| dir_wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Start byte address |
| len_sel_i | input | 2 | Length code (0/1/2/3 = 1/4/8/16 words) |
| wrap_en_i | input | 1 | Wrap within the aligned window |
| rd_burst_en_i | input | 1 | Allow bursts on reads |
| wr_burst_en_i | input | 1 | Allow bursts on writes |
| wide_i | input | 1 | 0 = 1-byte device, 1 = 2-byte device |
| gap_i | input | DLY_W | Idle cycles between words |
| ready_o | output | 1 | Idle and able to take a start |
| beat_o | output | 1 | A word address is valid this cycle |
| last_o | output | 1 | Current beat is the final one |
| wr_o | output | 1 | Direction of the current access |
| addr_o | output | ADDR_W | Current word byte address |

## Verification
The assertions check the following on every cycle:
- the first beat follows an accepted start directly;
- `last_o` appears only with a beat, and idle follows it;
- a non-final beat never returns to ready;
- the address is held through gap cycles;
- a zero gap yields consecutive beats;
- 2-byte addresses stay even.

The exact address order needs the bench's scenarios, which compare every beat against a queue computed from the requirements. This covers the length decode, the per-direction enable choice, linear and wrapped stepping with wrap-around at the window and at the top of the address space, and the spacing between beats. The bench also shows that a start or a changed setting mid-burst has no effect.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BEAT = 2'd1,
        ST_GAP  = 2'd2
    } seq_state_t;

    localparam logic [1:0] LEN_SINGLE = 2'd0;
    localparam logic [1:0] LEN_W4     = 2'd1;
    localparam logic [1:0] LEN_W8     = 2'd2;
    localparam logic [1:0] LEN_W16    = 2'd3;

    localparam int MAX_BEATS = 16;
    localparam int CNT_W     = $clog2(MAX_BEATS) + 1;
    localparam int WIN_LOG_W = 3;

endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [1:0]        len_sel,
    input  logic              dir_wr,
    input  logic              rd_burst_en,
    input  logic              wr_burst_en,
    input  logic              wide,
    output logic [CNT_W-1:0]  beats_m1,
    output logic [ADDR_W-1:0] win_mask
);

    logic                 burst_on;
    logic [1:0]           eff_code;
    logic [WIN_LOG_W-1:0] words_log;
    logic [WIN_LOG_W-1:0] win_log;

    always_comb begin
        burst_on = dir_wr ? wr_burst_en : rd_burst_en;
        eff_code = burst_on ? len_sel : LEN_SINGLE;
        unique case (eff_code)
            LEN_W4: begin
                beats_m1  = CNT_W'(3);
                words_log = WIN_LOG_W'(2);
            end
            LEN_W8: begin
                beats_m1  = CNT_W'(7);
                words_log = WIN_LOG_W'(3);
            end
            LEN_W16: begin
                beats_m1  = CNT_W'(15);
                words_log = WIN_LOG_W'(4);
            end
            default: begin
                beats_m1  = CNT_W'(0);
                words_log = WIN_LOG_W'(0);
            end
        endcase
        win_log = words_log + WIN_LOG_W'(wide);
    end

    for (genvar b = 0; b < ADDR_W; b++) begin : g_mask
        assign win_mask[b] = (b < int'(win_log));
    end

endmodule

// File: rtl/burst_addr_step.sv
module burst_addr_step #(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] cur,
    input  logic              wide,
    input  logic              wrap,
    input  logic [ADDR_W-1:0] win_mask,
    output logic [ADDR_W-1:0] nxt
);

    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] lin;

    always_comb begin
        step = {{(ADDR_W-2){1'b0}}, wide, ~wide};
        lin  = cur + step;
        if (wrap) begin
            nxt = (cur & ~win_mask) | (lin & win_mask);
        end else begin
            nxt = lin;
        end
    end

endmodule

// File: rtl/burst_gap_timer.sv
module burst_gap_timer #(
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DLY_W-1:0] load_val,
    input  logic             run,
    output logic             done
);

    logic [DLY_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - DLY_W'(1);
        end
    end

    assign done = run && (cnt_q <= DLY_W'(1));

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DLY_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              dir_wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        len_sel_i,
    input  logic              wrap_en_i,
    input  logic              rd_burst_en_i,
    input  logic              wr_burst_en_i,
    input  logic              wide_i,
    input  logic [DLY_W-1:0]  gap_i,
    output logic              ready_o,
    output logic              beat_o,
    output logic              last_o,
    output logic              wr_o,
    output logic [ADDR_W-1:0] addr_o
);

    seq_state_t        state_q;
    seq_state_t        state_d;

    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] mask_q;
    logic [CNT_W-1:0]  rem_q;
    logic [DLY_W-1:0]  gap_q;
    logic              wr_q;
    logic              wide_q;
    logic              wrap_q;

    logic [CNT_W-1:0]  dec_beats_m1;
    logic [ADDR_W-1:0] dec_mask;
    logic [ADDR_W-1:0] step_addr;
    logic [ADDR_W-1:0] start_aligned;
    logic              gap_done;
    logic              accept;
    logic              advance;

    burst_len_decode #(.ADDR_W(ADDR_W)) len_dec_i (
        .len_sel     (len_sel_i),
        .dir_wr      (dir_wr_i),
        .rd_burst_en (rd_burst_en_i),
        .wr_burst_en (wr_burst_en_i),
        .wide        (wide_i),
        .beats_m1    (dec_beats_m1),
        .win_mask    (dec_mask)
    );

    burst_addr_step #(.ADDR_W(ADDR_W)) step_i (
        .cur      (addr_q),
        .wide     (wide_q),
        .wrap     (wrap_q),
        .win_mask (mask_q),
        .nxt      (step_addr)
    );

    burst_gap_timer #(.DLY_W(DLY_W)) gap_tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (advance),
        .load_val (gap_q),
        .run      (state_q == ST_GAP),
        .done     (gap_done)
    );

    assign accept  = (state_q == ST_IDLE) && start_i;
    assign advance = (state_q == ST_BEAT) && (rem_q != '0);
    assign start_aligned = wide_i ? {addr_i[ADDR_W-1:1], 1'b0} : addr_i;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = ST_BEAT;
                end
            end
            ST_BEAT: begin
                if (rem_q == '0) begin
                    state_d = ST_IDLE;
                end else if (gap_q == '0) begin
                    state_d = ST_BEAT;
                end else begin
                    state_d = ST_GAP;
                end
            end
            ST_GAP: begin
                if (gap_done) begin
                    state_d = ST_BEAT;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Burst context, captured on accept and stepped per beat
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            mask_q <= '0;
            rem_q  <= '0;
            gap_q  <= '0;
            wr_q   <= 1'b0;
            wide_q <= 1'b0;
            wrap_q <= 1'b0;
        end else if (accept) begin
            addr_q <= start_aligned;
            mask_q <= dec_mask;
            rem_q  <= dec_beats_m1;
            gap_q  <= gap_i;
            wr_q   <= dir_wr_i;
            wide_q <= wide_i;
            wrap_q <= wrap_en_i;
        end else if (advance) begin
            addr_q <= step_addr;
            rem_q  <= rem_q - CNT_W'(1);
        end
    end

    // Outputs
    always_comb begin
        ready_o = (state_q == ST_IDLE);
        beat_o  = (state_q == ST_BEAT);
        last_o  = (state_q == ST_BEAT) && (rem_q == '0);
        wr_o    = wr_q;
        addr_o  = addr_q;
    end

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
    parameter int ADDR_W = 16,
    parameter int DLY_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              ready_o,
    input logic              beat_o,
    input logic              last_o,
    input logic [ADDR_W-1:0] addr_o,
    input logic              wide_q,
    input logic [DLY_W-1:0]  gap_q
);

    AST_START_TO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && start_i) |=> beat_o); // R2

    AST_LAST_WITH_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> beat_o); // R3

    AST_WIDE_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_o && wide_q) |-> !addr_o[0]); // R5

    AST_GAP_HOLDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_o && !beat_o && $past(!ready_o && !beat_o)) |-> $stable(addr_o)); // R8

    AST_NOGAP_BACK2BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_o && !last_o && gap_q == '0) |=> beat_o); // R8

    AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_o && last_o) |=> (ready_o && !beat_o)); // R9

    AST_BUSY_STAYS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_o && !last_o) |=> !ready_o); // R10

    AST_READY_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> !beat_o); // R1

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .DLY_W(DLY_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .ready_o (ready_o),
    .beat_o  (beat_o),
    .last_o  (last_o),
    .addr_o  (addr_o),
    .wide_q  (wide_q),
    .gap_q   (gap_q)
);

// File: tb/burst_addr_seq_tb_top.sv
`timescale 1ns/1ps
module burst_addr_seq_tb_top;

    localparam int ADDR_W = 16;
    localparam int DLY_W  = 4;

    typedef struct {
        logic [ADDR_W-1:0] addr;
        logic              last;
        logic              wr;
        int                gap;
        string             tag;
    } exp_beat_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic              dir_wr_i = 1'b0;
    logic [ADDR_W-1:0] addr_i = '0;
    logic [1:0]        len_sel_i = '0;
    logic              wrap_en_i = 1'b0;
    logic              rd_burst_en_i = 1'b0;
    logic              wr_burst_en_i = 1'b0;
    logic              wide_i = 1'b0;
    logic [DLY_W-1:0]  gap_i = '0;
    logic              ready_o;
    logic              beat_o;
    logic              last_o;
    logic              wr_o;
    logic [ADDR_W-1:0] addr_o;

    int checks = 0;
    int errors = 0;
    exp_beat_t exp_q[$];
    bit mon_en = 1'b0;
    bit after_last = 1'b0;
    int since_beat = 0;

    always #2.5 clk = ~clk;

    burst_addr_seq #(.ADDR_W(ADDR_W), .DLY_W(DLY_W)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .dir_wr_i      (dir_wr_i),
        .addr_i        (addr_i),
        .len_sel_i     (len_sel_i),
        .wrap_en_i     (wrap_en_i),
        .rd_burst_en_i (rd_burst_en_i),
        .wr_burst_en_i (wr_burst_en_i),
        .wide_i        (wide_i),
        .gap_i         (gap_i),
        .ready_o       (ready_o),
        .beat_o        (beat_o),
        .last_o        (last_o),
        .wr_o          (wr_o),
        .addr_o        (addr_o)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected beats and compares
    always @(negedge clk) begin
        if (mon_en) begin
            since_beat++;
            if (after_last) begin
                check(ready_o && !beat_o, "R9 ready after last", {ready_o, beat_o}, 2'b10);
                after_last = 1'b0;
            end
            if (beat_o) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10 unexpected beat", addr_o, 0);
                end else begin
                    exp_beat_t e;
                    e = exp_q.pop_front();
                    check(addr_o == e.addr, {e.tag, " addr"}, addr_o, e.addr);
                    check(last_o == e.last, "R3 last flag", last_o, e.last);
                    check(wr_o == e.wr, "R2 direction", wr_o, e.wr);
                    if (e.gap >= 0) begin
                        check(since_beat == e.gap + 1, "R8 beat spacing", since_beat, e.gap + 1);
                    end
                    if (last_o) after_last = 1'b1;
                end
                since_beat = 0;
            end
        end
    end

    task automatic run_burst(input logic wr, input logic [ADDR_W-1:0] a, input logic [1:0] len,
                             input logic wrap, input logic rd_en, input logic wr_en,
                             input logic wide, input int gap, input string tag, input bit poke);
        int n;
        int step;
        int first;
        int win;
        int base;
        bit burst_on;
        burst_on = wr ? wr_en : rd_en;
        n = (!burst_on || len == 2'd0) ? 1 : (len == 2'd1 ? 4 : (len == 2'd2 ? 8 : 16));
        step = wide ? 2 : 1;
        first = wide ? (int'(a) & 32'hFFFE) : int'(a);
        win = n * step;
        base = first - (first % win);
        for (int k = 0; k < n; k++) begin
            exp_beat_t e;
            if (wrap) e.addr = ADDR_W'(base + ((first - base + k * step) % win));
            else      e.addr = ADDR_W'(first + k * step);
            e.last = (k == n - 1);
            e.wr   = wr;
            e.gap  = (k == 0) ? -1 : gap;
            e.tag  = tag;
            exp_q.push_back(e);
        end
        @(negedge clk);
        while (!ready_o) @(negedge clk);
        dir_wr_i = wr; addr_i = a; len_sel_i = len; wrap_en_i = wrap;
        rd_burst_en_i = rd_en; wr_burst_en_i = wr_en; wide_i = wide; gap_i = DLY_W'(gap);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (poke) begin
            // R10 and R11: start and changed settings while busy
            repeat (3) @(negedge clk);
            dir_wr_i = ~wr; addr_i = ~a; len_sel_i = 2'd1; wrap_en_i = ~wrap;
            wide_i = ~wide; gap_i = '0; rd_burst_en_i = 1'b1; wr_burst_en_i = 1'b1;
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(ready_o && !beat_o && !last_o, "R1 reset state", {ready_o, beat_o, last_o}, 3'b100);
        rst_n = 1'b1;
        mon_en = 1'b1;
        // R6: linear, 1-byte, 4 words, back-to-back
        run_burst(1'b0, 16'h0102, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 0, "R6 linear byte", 1'b0);
        drain();
        // R7 + R5: wrap, 2-byte, 8 words, gap 1
        run_burst(1'b0, 16'h0036, 2'd2, 1'b1, 1'b1, 1'b0, 1'b1, 1, "R7 wrap wide", 1'b0);
        drain();
        // R4: write with write bursts off -> single
        run_burst(1'b1, 16'h0200, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 0, "R4 write single", 1'b0);
        drain();
        // R7: write wrap, byte width, 16 words, gap 2
        run_burst(1'b1, 16'h00FD, 2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 2, "R7 wrap write", 1'b0);
        drain();
        // R3: length code 0 gives one word
        run_burst(1'b0, 16'h0444, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 0, "R3 single code", 1'b0);
        drain();
        // R6: linear wrap of the address space, 2-byte
        run_burst(1'b0, 16'hFFFE, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 0, "R6 top rollover", 1'b0);
        drain();
        // R4: read with read bursts off -> single
        run_burst(1'b0, 16'h0800, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 0, "R4 read single", 1'b0);
        drain();
        // R10/R11: start and settings change mid-burst
        run_burst(1'b0, 16'h1000, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 2, "R10 busy ignore", 1'b1);
        drain();
        // R9: back-to-back bursts
        run_burst(1'b1, 16'h2000, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 0, "R9 first", 1'b0);
        run_burst(1'b0, 16'h3001, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 0, "R9 second", 1'b0);
        drain();
        // R5: odd start with 2-byte width is aligned down
        run_burst(1'b0, 16'h0011, 2'd1, 1'b0, 1'b1, 1'b0, 1'b1, 0, "R5 align", 1'b0);
        drain();
        // R8: maximum gap
        run_burst(1'b1, 16'h0500, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 15, "R8 max gap", 1'b0);
        drain();
        finish_run();
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=0", exp_q.size());
        finish_run();
    end

endmodule